// File: doc/BRIEF.md
# Duplex Packet DMA Engine

This block moves fixed-size packets between memory and a wide streaming port in both directions at once, through a single AXI4 master with a 64-bit data bus. The fetch direction reads each packet from memory as one 3-beat incrementing burst. It hands the packet to the outbound valid/ready stream as a single 192-bit word. The store direction takes 192-bit words from the inbound valid/ready stream and writes each one to memory as a 3-beat burst.

Each direction has its own start level, byte address, 32-bit packet count, busy flag and done flag. A controller raises start and holds it until the engine reports busy (or done, for an empty job). Packets are laid out back to back in memory, 24 bytes apart. The two directions share only the master port: reads use the AR/R channels and writes use the AW/W/B channels, so the two directions never contend.

Top module: `pkt_dma_duplex`

## Requirements
- R1: During and just after reset, both busy flags, both done flags, `ar_valid`, `aw_valid`, `w_valid`, `out_tvalid` and `in_tready` are low.
- R2: Every read and write address carries length field 2 (3 beats), size code 3 (8 bytes) and burst type INCR (2'b01). Every write beat has `w_strb` = 8'hFF.
- R3: Packet k of a fetch job (k from 0) is requested at address source + 24*k. At most one read burst is outstanding. A pending request holds `ar_valid` and `ar_addr` steady until it is accepted.
- R4: The outbound word places the first read beat in bits [63:0], the second in [127:64] and the third in [191:128]. `out_tvalid` rises only when the third beat is on the read-data channel.
- R5: The third read beat drives bits [191:128] straight from `r_data` in the same cycle. While the outbound stream stalls, `r_ready` stays low for that beat. The first two beats are taken without waiting for the stream.
- R6: Store packet k is written as one burst at address destination + 24*k. Beat i carries bits [64*i+63:64*i] of the inbound word. `w_last` is high on the third beat only. Write address and data are held steady while they wait.
- R7: After an inbound word is accepted, `in_tready` stays low until that packet's write response has been accepted.
- R8: A stored packet counts as complete only when its write response arrives. `tx_done` rises only after the last write response of the job.
- R9: A job of N packets (32-bit count) issues exactly N bursts in its direction. At the end, done is high and busy is low.
- R10: Done stays high until the next launch of the same direction, and that launch clears it.
- R11: A job started with a count of zero sets done one cycle after start is sampled. Busy stays low and the job issues no bus traffic.
- R12: Both directions can be started together and run at the same time, each with its own address, count and flags.
- R13: A job launches when start is sampled high while its direction is idle. Busy (or done for an empty job) is visible one cycle later. If start stays high after completion, no second job starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_start | input | 1 | Fetch start level |
| rx_src_addr | input | ADDR_W | Fetch source byte address |
| rx_pkt_count | input | CNT_W | Fetch packet count |
| rx_busy | output | 1 | Fetch job running |
| rx_done | output | 1 | Fetch job finished (sticky) |
| tx_start | input | 1 | Store start level |
| tx_dst_addr | input | ADDR_W | Store destination byte address |
| tx_pkt_count | input | CNT_W | Store packet count |
| tx_busy | output | 1 | Store job running |
| tx_done | output | 1 | Store job finished (sticky) |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Read address |
| ar_len | output | 8 | Read burst length field |
| ar_size | output | 3 | Read beat size code |
| ar_burst | output | 2 | Read burst type |
| ar_id | output | ID_W | Read transaction ID |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | DATA_W | Read data |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Write address |
| aw_len | output | 8 | Write burst length field |
| aw_size | output | 3 | Write beat size code |
| aw_burst | output | 2 | Write burst type |
| aw_id | output | ID_W | Write transaction ID |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | DATA_W | Write data |
| w_strb | output | DATA_W/8 | Write byte strobes |
| w_last | output | 1 | Last write beat |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| out_tdata | output | BEATS*DATA_W | Outbound packet word |
| out_tvalid | output | 1 | Outbound word valid |
| out_tready | input | 1 | Outbound sink ready |
| in_tdata | input | BEATS*DATA_W | Inbound packet word |
| in_tvalid | input | 1 | Inbound word valid |
| in_tready | output | 1 | Inbound accept |

## Verification
The risky overlap is a third read beat arriving in the same cycle as a stall on the outbound stream. The stream's backpressure then has to reach `r_ready` through combinational logic, and the same cycle may also carry a write burst beat or write response from the other direction. The bench provokes this by letting a random memory model and a random stream sink throttle both sides independently while both directions run together. Every outbound word is compared with a packet assembled from the memory model. In every cycle where `out_tvalid` is high, the upper slice must equal `r_data` and `r_ready` must equal `out_tready`. Memory written by the store direction is compared slice by slice with the packets sent.

// File: rtl/dma_pkg.sv
// Shared types for the duplex packet DMA.
// Assumes nothing beyond a single synchronous clock domain.
package dma_pkg;

    // Fetch-direction sequencer states.
    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ADDR,
        RD_DATA
    } rd_state_t;

    // Store-direction sequencer states.
    typedef enum logic [2:0] {
        WR_IDLE,
        WR_FETCH,
        WR_ADDR,
        WR_DATA,
        WR_RESP
    } wr_state_t;

    // AXI burst type code for incrementing bursts.
    localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/dma_start_gate.sv
// Converts a start level into a single launch pulse.
// A launch needs start high, the engine idle, and start seen low since the
// previous launch, so one held level never yields two jobs.
module dma_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic idle,
    output logic launch
);
    logic armed_q;

    assign launch = start && armed_q && idle;

    // Disarm on launch, rearm once start has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (launch) begin
            armed_q <= 1'b0;
        end else if (!start) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_rd_engine.sv
// Fetch direction: reads BEATS-beat bursts and presents each packet as one
// wide word. Beats 0..BEATS-2 land in holding registers; the final beat is
// routed straight from the read-data channel to the top slice, so its
// acceptance is tied to the outbound stream's ready.
// Assumes BEATS >= 2 and one read burst outstanding at a time.
module dma_rd_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 3,
    parameter int CNT_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic [ADDR_W-1:0]         src_addr,
    input  logic [CNT_W-1:0]          pkt_count,
    output logic                      busy,
    output logic                      done,
    output logic                      ar_valid,
    input  logic                      ar_ready,
    output logic [ADDR_W-1:0]         ar_addr,
    input  logic                      r_valid,
    output logic                      r_ready,
    input  logic [DATA_W-1:0]         r_data,
    output logic [BEATS*DATA_W-1:0]   out_tdata,
    output logic                      out_tvalid,
    input  logic                      out_tready
);
    import dma_pkg::*;

    localparam int LAST      = BEATS - 1;
    localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int PKT_BYTES = BEATS * DATA_W / 8;

    rd_state_t              state_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [CNT_W-1:0]       left_q;
    logic [BEAT_W-1:0]      beat_q;
    logic                   done_q;
    logic                   final_beat;
    logic                   rd_fire;

    assign final_beat = (beat_q == BEAT_W'(LAST));
    assign busy       = (state_q != RD_IDLE);
    assign done       = done_q;
    assign ar_valid   = (state_q == RD_ADDR);
    assign ar_addr    = addr_q;
    assign r_ready    = (state_q == RD_DATA) && (!final_beat || out_tready);
    assign out_tvalid = (state_q == RD_DATA) && final_beat && r_valid;
    assign rd_fire    = r_valid && r_ready;

    // Final slice bypasses the holding registers.
    assign out_tdata[LAST*DATA_W +: DATA_W] = r_data;

    // One holding register per early beat.
    for (genvar g = 0; g < LAST; g++) begin : g_hold
        logic [DATA_W-1:0] slice_q;

        // Capture beat g when it is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slice_q <= '0;
            end else if (rd_fire && (beat_q == BEAT_W'(g))) begin
                slice_q <= r_data;
            end
        end

        assign out_tdata[g*DATA_W +: DATA_W] = slice_q;
    end

    // Job sequencer: address phase, data phase, packet and job accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            beat_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                RD_IDLE: begin
                    if (launch) begin
                        addr_q <= src_addr;
                        left_q <= pkt_count;
                        if (pkt_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            state_q <= RD_ADDR;
                        end
                    end
                end
                RD_ADDR: begin
                    if (ar_ready) begin
                        beat_q  <= '0;
                        state_q <= RD_DATA;
                    end
                end
                RD_DATA: begin
                    if (rd_fire) begin
                        if (final_beat) begin
                            addr_q <= addr_q + ADDR_W'(PKT_BYTES);
                            left_q <= left_q - CNT_W'(1);
                            if (left_q == CNT_W'(1)) begin
                                done_q  <= 1'b1;
                                state_q <= RD_IDLE;
                            end else begin
                                state_q <= RD_ADDR;
                            end
                        end else begin
                            beat_q <= beat_q + BEAT_W'(1);
                        end
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_wr_engine.sv
// Store direction: takes one wide word from the inbound stream, writes it as
// a BEATS-beat burst lowest slice first, and waits for the write response
// before taking the next word. The inbound stream is stalled meanwhile.
// Assumes BEATS >= 2 and the address phase completes before the data phase.
module dma_wr_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 3,
    parameter int CNT_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic [ADDR_W-1:0]         dst_addr,
    input  logic [CNT_W-1:0]          pkt_count,
    output logic                      busy,
    output logic                      done,
    output logic                      aw_valid,
    input  logic                      aw_ready,
    output logic [ADDR_W-1:0]         aw_addr,
    output logic                      w_valid,
    input  logic                      w_ready,
    output logic [DATA_W-1:0]         w_data,
    output logic                      w_last,
    input  logic                      b_valid,
    output logic                      b_ready,
    input  logic [BEATS*DATA_W-1:0]   in_tdata,
    input  logic                      in_tvalid,
    output logic                      in_tready
);
    import dma_pkg::*;

    localparam int LAST      = BEATS - 1;
    localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int PKT_BYTES = BEATS * DATA_W / 8;
    localparam int PKT_W     = BEATS * DATA_W;

    wr_state_t              state_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [CNT_W-1:0]       left_q;
    logic [BEAT_W-1:0]      beat_q;
    logic                   done_q;
    logic [PKT_W-1:0]       shift_q;

    assign busy      = (state_q != WR_IDLE);
    assign done      = done_q;
    assign in_tready = (state_q == WR_FETCH);
    assign aw_valid  = (state_q == WR_ADDR);
    assign aw_addr   = addr_q;
    assign w_valid   = (state_q == WR_DATA);
    assign w_data    = shift_q[DATA_W-1:0];
    assign w_last    = (state_q == WR_DATA) && (beat_q == BEAT_W'(LAST));
    assign b_ready   = (state_q == WR_RESP);

    // Packet buffer: load from the stream, shift one slice per write beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (in_tvalid && in_tready) begin
            shift_q <= in_tdata;
        end else if (w_valid && w_ready) begin
            shift_q <= {DATA_W'(0), shift_q[PKT_W-1:DATA_W]};
        end
    end

    // Job sequencer: fetch word, address phase, data beats, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            beat_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                WR_IDLE: begin
                    if (launch) begin
                        addr_q <= dst_addr;
                        left_q <= pkt_count;
                        if (pkt_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            state_q <= WR_FETCH;
                        end
                    end
                end
                WR_FETCH: begin
                    if (in_tvalid) begin
                        state_q <= WR_ADDR;
                    end
                end
                WR_ADDR: begin
                    if (aw_ready) begin
                        beat_q  <= '0;
                        state_q <= WR_DATA;
                    end
                end
                WR_DATA: begin
                    if (w_ready) begin
                        if (beat_q == BEAT_W'(LAST)) begin
                            state_q <= WR_RESP;
                        end else begin
                            beat_q <= beat_q + BEAT_W'(1);
                        end
                    end
                end
                WR_RESP: begin
                    if (b_valid) begin
                        addr_q <= addr_q + ADDR_W'(PKT_BYTES);
                        left_q <= left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            done_q  <= 1'b1;
                            state_q <= WR_IDLE;
                        end else begin
                            state_q <= WR_FETCH;
                        end
                    end
                end
                default: state_q <= WR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkt_dma_duplex.sv
// Duplex packet DMA top: a fetch engine on the AR/R channels and a store
// engine on the AW/W/B channels of one AXI4 master, each with its own start
// gate. Burst attributes are fixed: BEATS beats of DATA_W bits, INCR.
// Assumes DATA_W is a power of two of at least 8 bits and BEATS >= 2.
module pkt_dma_duplex #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 3,
    parameter int CNT_W  = 32,
    parameter int ID_W   = 4,
    parameter int RD_ID  = 0,
    parameter int WR_ID  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_start,
    input  logic [ADDR_W-1:0]        rx_src_addr,
    input  logic [CNT_W-1:0]         rx_pkt_count,
    output logic                     rx_busy,
    output logic                     rx_done,
    input  logic                     tx_start,
    input  logic [ADDR_W-1:0]        tx_dst_addr,
    input  logic [CNT_W-1:0]         tx_pkt_count,
    output logic                     tx_busy,
    output logic                     tx_done,
    output logic                     ar_valid,
    input  logic                     ar_ready,
    output logic [ADDR_W-1:0]        ar_addr,
    output logic [7:0]               ar_len,
    output logic [2:0]               ar_size,
    output logic [1:0]               ar_burst,
    output logic [ID_W-1:0]          ar_id,
    input  logic                     r_valid,
    output logic                     r_ready,
    input  logic [DATA_W-1:0]        r_data,
    output logic                     aw_valid,
    input  logic                     aw_ready,
    output logic [ADDR_W-1:0]        aw_addr,
    output logic [7:0]               aw_len,
    output logic [2:0]               aw_size,
    output logic [1:0]               aw_burst,
    output logic [ID_W-1:0]          aw_id,
    output logic                     w_valid,
    input  logic                     w_ready,
    output logic [DATA_W-1:0]        w_data,
    output logic [DATA_W/8-1:0]      w_strb,
    output logic                     w_last,
    input  logic                     b_valid,
    output logic                     b_ready,
    output logic [BEATS*DATA_W-1:0]  out_tdata,
    output logic                     out_tvalid,
    input  logic                     out_tready,
    input  logic [BEATS*DATA_W-1:0]  in_tdata,
    input  logic                     in_tvalid,
    output logic                     in_tready
);
    import dma_pkg::*;

    localparam logic [7:0] LEN_CODE  = 8'(BEATS - 1);
    localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_W / 8));

    logic rx_launch;
    logic tx_launch;

    // Fixed burst attributes for both directions.
    assign ar_len   = LEN_CODE;
    assign ar_size  = SIZE_CODE;
    assign ar_burst = BURST_INCR;
    assign ar_id    = ID_W'(RD_ID);
    assign aw_len   = LEN_CODE;
    assign aw_size  = SIZE_CODE;
    assign aw_burst = BURST_INCR;
    assign aw_id    = ID_W'(WR_ID);
    assign w_strb   = '1;

    dma_start_gate u_rx_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rx_start),
        .idle   (!rx_busy),
        .launch (rx_launch)
    );

    dma_start_gate u_tx_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tx_start),
        .idle   (!tx_busy),
        .launch (tx_launch)
    );

    dma_rd_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS),
        .CNT_W  (CNT_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (rx_launch),
        .src_addr   (rx_src_addr),
        .pkt_count  (rx_pkt_count),
        .busy       (rx_busy),
        .done       (rx_done),
        .ar_valid   (ar_valid),
        .ar_ready   (ar_ready),
        .ar_addr    (ar_addr),
        .r_valid    (r_valid),
        .r_ready    (r_ready),
        .r_data     (r_data),
        .out_tdata  (out_tdata),
        .out_tvalid (out_tvalid),
        .out_tready (out_tready)
    );

    dma_wr_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS),
        .CNT_W  (CNT_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (tx_launch),
        .dst_addr  (tx_dst_addr),
        .pkt_count (tx_pkt_count),
        .busy      (tx_busy),
        .done      (tx_done),
        .aw_valid  (aw_valid),
        .aw_ready  (aw_ready),
        .aw_addr   (aw_addr),
        .w_valid   (w_valid),
        .w_ready   (w_ready),
        .w_data    (w_data),
        .w_last    (w_last),
        .b_valid   (b_valid),
        .b_ready   (b_ready),
        .in_tdata  (in_tdata),
        .in_tvalid (in_tvalid),
        .in_tready (in_tready)
    );
endmodule

// File: rtl/dma_duplex_checker.sv
// Protocol and ordering checks for pkt_dma_duplex, bound to every instance.
module dma_duplex_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_start,
    input logic              rx_done,
    input logic              tx_start,
    input logic              tx_done,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [ADDR_W-1:0] ar_addr,
    input logic              r_ready,
    input logic              out_tvalid,
    input logic              out_tready,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic [ADDR_W-1:0] aw_addr,
    input logic              w_valid,
    input logic              w_ready,
    input logic [DATA_W-1:0] w_data,
    input logic              w_last,
    input logic              b_valid,
    input logic              b_ready,
    input logic              in_tvalid,
    input logic              in_tready
);
    assert_ar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));

    assert_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> !r_ready);

    assert_bypass_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tvalid && !out_tready) |-> !r_ready);

    assert_aw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr)));

    assert_w_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_ready) |=> (w_valid && $stable(w_data) && $stable(w_last)));

    assert_in_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tvalid && in_tready) |=> !in_tready);

    assert_tx_done_after_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> ($past(b_valid && b_ready) || $past(tx_start)));

    assert_rx_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done) |-> $past(rx_start));

    assert_tx_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_done) |-> $past(tx_start));
endmodule

bind pkt_dma_duplex dma_duplex_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_dma_chk (.*);

// File: tb/tb_pkt_dma_duplex.sv
module tb_pkt_dma_duplex;
    localparam int MEMW = 256;

    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;

    logic rx_start, tx_start, rx_busy, rx_done, tx_busy, tx_done;
    logic [31:0] rx_src_addr, rx_pkt_count, tx_dst_addr, tx_pkt_count;
    logic ar_valid, ar_ready, r_valid, r_ready, aw_valid, aw_ready;
    logic [31:0] ar_addr, aw_addr;
    logic [7:0] ar_len, aw_len;
    logic [2:0] ar_size, aw_size;
    logic [1:0] ar_burst, aw_burst;
    logic [3:0] ar_id, aw_id;
    logic [63:0] r_data, w_data;
    logic w_valid, w_ready, w_last, b_valid, b_ready;
    logic [7:0] w_strb;
    logic [191:0] out_tdata, in_tdata;
    logic out_tvalid, out_tready, in_tvalid, in_tready;

    pkt_dma_duplex dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [191:0] act,
                       input logic [191:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    logic [63:0]  mem [MEMW];
    logic [191:0] tx_pkts [16];
    logic [31:0]  rx_src_cur, tx_dst_cur;
    int ar_seen, out_seen, aw_seen, b_seen, in_idx, tx_n_cur;
    bit both_busy;

    function automatic logic [191:0] exp_pkt(input logic [31:0] a);
        int w;
        w = int'(a >> 3);
        return {mem[(w + 2) % MEMW], mem[(w + 1) % MEMW], mem[w % MEMW]};
    endfunction

    // Read-side memory model.
    initial begin
        bit rd_active, rfire;
        int rd_w, rd_beat;
        ar_ready = 0; r_valid = 0; r_data = '0;
        rd_active = 0; rfire = 0; rd_w = 0; rd_beat = 0;
        forever begin
            @(negedge clk);
            if (rfire) begin
                r_valid = 0;
                rd_beat++;
                if (rd_beat == 3) rd_active = 0;
            end
            ar_ready = !rd_active && ($urandom % 4 != 0);
            if (rd_active && !r_valid) r_valid = ($urandom % 3 != 0);
            r_data = mem[(rd_w + rd_beat) % MEMW];
            #1;
            rfire = 0;
            if (ar_valid && ar_ready) begin
                chk(ar_addr == rx_src_cur + 32'(24 * ar_seen), "R3 read address",
                    192'(ar_addr), 192'(rx_src_cur + 32'(24 * ar_seen)));
                chk({ar_len, ar_size, ar_burst} == {8'd2, 3'd3, 2'b01}, "R2 read attributes",
                    192'({ar_len, ar_size, ar_burst}), 192'({8'd2, 3'd3, 2'b01}));
                ar_seen++;
                rd_active = 1; rd_w = int'(ar_addr >> 3); rd_beat = 0;
            end
            if (r_valid && r_ready) rfire = 1;
        end
    end

    // Outbound stream sink.
    initial begin
        out_tready = 0;
        forever begin
            @(negedge clk);
            out_tready = ($urandom % 3 != 0);
            #1;
            if (out_tvalid) begin
                chk(r_valid && out_tdata[191:128] == r_data && r_ready == out_tready,
                    "R5 final beat bypass", 192'(out_tdata[191:128]), 192'(r_data));
            end
            if (out_tvalid && out_tready) begin
                chk(out_tdata == exp_pkt(rx_src_cur + 32'(24 * out_seen)), "R4 outbound word",
                    out_tdata, exp_pkt(rx_src_cur + 32'(24 * out_seen)));
                out_seen++;
            end
        end
    end

    // Write-side memory model.
    initial begin
        bit have_aw, need_b, wfire, bfire;
        int wr_w, wr_beat, b_delay;
        aw_ready = 0; w_ready = 0; b_valid = 0;
        have_aw = 0; need_b = 0; wfire = 0; bfire = 0; wr_w = 0; wr_beat = 0; b_delay = 0;
        forever begin
            @(negedge clk);
            if (wfire) begin
                wr_beat++;
                if (wr_beat == 3) begin
                    have_aw = 0; need_b = 1; b_delay = int'($urandom % 4);
                end
            end
            if (bfire) begin
                b_valid = 0; need_b = 0; b_seen++;
            end
            aw_ready = !have_aw && !need_b && ($urandom % 3 != 0);
            w_ready = have_aw && ($urandom % 3 != 0);
            if (need_b && !b_valid) begin
                if (b_delay == 0) b_valid = 1;
                else b_delay--;
            end
            #1;
            wfire = 0; bfire = 0;
            if (have_aw || need_b)
                chk(!in_tready, "R7 inbound stalled during burst", 192'(in_tready), 192'(0));
            if (need_b && aw_seen == tx_n_cur)
                chk(!tx_done, "R8 done before last response", 192'(tx_done), 192'(0));
            if (aw_valid && aw_ready) begin
                chk(aw_addr == tx_dst_cur + 32'(24 * aw_seen), "R6 write address",
                    192'(aw_addr), 192'(tx_dst_cur + 32'(24 * aw_seen)));
                chk({aw_len, aw_size, aw_burst} == {8'd2, 3'd3, 2'b01}, "R2 write attributes",
                    192'({aw_len, aw_size, aw_burst}), 192'({8'd2, 3'd3, 2'b01}));
                aw_seen++;
                have_aw = 1; wr_w = int'(aw_addr >> 3); wr_beat = 0;
            end
            if (w_valid && w_ready) begin
                chk(w_strb == 8'hFF, "R2 write strobes", 192'(w_strb), 192'(8'hFF));
                chk(w_last == (wr_beat == 2), "R6 last flag", 192'(w_last), 192'(wr_beat == 2));
                mem[(wr_w + wr_beat) % MEMW] = w_data;
                wfire = 1;
            end
            if (b_valid && b_ready) bfire = 1;
        end
    end

    // Inbound stream source.
    initial begin
        bit ifire;
        in_tvalid = 0; in_tdata = '0; ifire = 0;
        forever begin
            @(negedge clk);
            if (ifire) begin
                in_tvalid = 0; in_idx++;
            end
            if (in_idx < tx_n_cur && in_idx < 16 && !in_tvalid) in_tvalid = $urandom % 2;
            in_tdata = tx_pkts[in_idx % 16];
            #1;
            ifire = in_tvalid && in_tready;
        end
    end

    // Concurrency monitor.
    initial begin
        both_busy = 0;
        forever begin
            @(negedge clk); #1;
            if (rx_busy && tx_busy) both_busy = 1;
        end
    end

    // Launch one or both directions; optionally keep start high afterwards.
    task automatic run_job(input bit do_rx, input logic [31:0] src, input int rn,
                           input bit do_tx, input logic [31:0] dst, input int tn,
                           input bit hold);
        int guard;
        if (do_rx) begin
            rx_src_cur = src; ar_seen = 0; out_seen = 0;
            rx_src_addr = src; rx_pkt_count = 32'(rn);
        end
        if (do_tx) begin
            tx_dst_cur = dst; aw_seen = 0; b_seen = 0;
            for (int k = 0; k < 16; k++)
                tx_pkts[k] = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            tx_dst_addr = dst; tx_pkt_count = 32'(tn);
            in_idx = 0; tx_n_cur = tn;
        end
        @(negedge clk);
        rx_start = do_rx; tx_start = do_tx;
        @(negedge clk); #1;
        if (do_rx)
            chk(rn == 0 ? (rx_done && !rx_busy) : (rx_busy && !rx_done),
                "R13 fetch launch response", 192'({rx_busy, rx_done}),
                192'(rn == 0 ? 2'b01 : 2'b10));
        if (do_tx)
            chk(tn == 0 ? (tx_done && !tx_busy) : (tx_busy && !tx_done),
                "R13 store launch response", 192'({tx_busy, tx_done}),
                192'(tn == 0 ? 2'b01 : 2'b10));
        if (!hold) begin
            rx_start = 0; tx_start = 0;
        end
        guard = 0;
        while (((do_rx && !rx_done) || (do_tx && !tx_done)) && guard < 20000) begin
            @(negedge clk); #1;
            guard++;
        end
        chk(guard < 20000, "R9 job completes", 192'(guard), 192'(0));
        if (do_rx) begin
            chk(ar_seen == rn && out_seen == rn && !rx_busy, "R9 fetch packet count",
                192'(out_seen), 192'(rn));
        end
        if (do_tx) begin
            chk(aw_seen == tn && b_seen == tn && !tx_busy, "R9 store packet count",
                192'(b_seen), 192'(tn));
            chk(b_seen == tn, "R8 responses before done", 192'(b_seen), 192'(tn));
            for (int k = 0; k < tn; k++) begin
                logic [191:0] got;
                got = exp_pkt(dst + 32'(24 * k));
                chk(got == tx_pkts[k], "R6 memory image", got, tx_pkts[k]);
            end
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < MEMW; i++) mem[i] = {$urandom, $urandom};
        rx_src_cur = 0; tx_dst_cur = 0; ar_seen = 0; out_seen = 0;
        aw_seen = 0; b_seen = 0; in_idx = 0; tx_n_cur = 0;
        rst_n = 0; rx_start = 0; tx_start = 0;
        rx_src_addr = '0; rx_pkt_count = '0; tx_dst_addr = '0; tx_pkt_count = '0;
        repeat (5) @(negedge clk);
        #1;
        chk({rx_busy, rx_done, tx_busy, tx_done, ar_valid, aw_valid, w_valid, out_tvalid,
             in_tready} == 9'd0, "R1 reset state",
            192'({rx_busy, rx_done, tx_busy, tx_done, ar_valid, aw_valid, w_valid,
                  out_tvalid, in_tready}), 192'(0));
        @(negedge clk);
        rst_n = 1;

        // Directed: fetch only, store only, then both together (R12).
        run_job(1, 32'h40, 4, 0, 0, 0, 0);
        run_job(0, 0, 0, 1, 32'h420, 3, 0);
        both_busy = 0;
        run_job(1, 32'h100, 5, 1, 32'h500, 5, 0);
        chk(both_busy, "R12 directions overlap", 192'(both_busy), 192'(1));

        // R10: done stays high while idle.
        repeat (20) @(negedge clk);
        #1;
        chk(rx_done && tx_done, "R10 done sticky", 192'({rx_done, tx_done}), 192'(2'b11));

        // R11: zero-count jobs.
        ar_seen = 0; aw_seen = 0;
        run_job(1, 32'h80, 0, 1, 32'h600, 0, 0);
        repeat (10) @(negedge clk);
        #1;
        chk(ar_seen == 0 && aw_seen == 0 && !rx_busy && !tx_busy, "R11 zero count silent",
            192'({ar_seen[7:0], aw_seen[7:0]}), 192'(0));

        // R10: a new launch clears done (checked by the R13 launch response) and R13 hold.
        run_job(1, 32'h58, 2, 0, 0, 0, 1);
        repeat (30) @(negedge clk);
        #1;
        chk(ar_seen == 2 && !rx_busy && rx_done, "R13 held start no relaunch",
            192'(ar_seen), 192'(2));
        rx_start = 0;
        @(negedge clk);

        // Random concurrent jobs.
        for (int it = 0; it < 8; it++) begin
            int rn, tn;
            logic [31:0] sa, da;
            rn = 1 + int'($urandom % 6);
            tn = 1 + int'($urandom % 6);
            sa = 32'(($urandom % 100) * 8);
            da = 32'((128 + ($urandom % 100)) * 8);
            both_busy = 0;
            run_job(1, sa, rn, 1, da, tn, 0);
            chk(both_busy, "R12 random overlap", 192'(both_busy), 192'(1));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule